// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU input registers of a five-stage in-order pipeline. It chooses the two operand values used by the instruction in the execute stage (stage 3). Normally these come from the register file read done during decode. When an older instruction still in the pipeline is about to write one of the source registers, the block takes the newer value from a later stage instead of waiting for write-back. The sources are the ALU result held in the memory-stage register (stage 4) and the result held in the write-back-stage register (stage 5).

A loaded value does not exist until the memory access has finished. So a load sitting in stage 4 can never supply a value. If the execute-stage instruction needs that load's destination, the block raises a stall request instead. The pipeline control then holds the consumer for one cycle and puts a bubble into stage 4. On the next cycle the load has reached stage 5 and its data is forwarded from there. The whole block is combinational. It compares the register fields and opcode classes that each pipeline register carries forward with its instruction.

Top module: `opfwd_unit`

## Requirements
- R1: When the execute-stage instruction is ALU-class, the stage-5 instruction writes a register (ALU or load class), and its destination equals the execute-stage rb, `x_val` equals `wb_res`.
- R2: When the execute-stage instruction is ALU-class and not immediate, the stage-5 instruction writes a register, and its destination equals the execute-stage rc, `y_val` equals `wb_res`.
- R3: When the execute-stage instruction is ALU-class and the stage-4 instruction is ALU-class, a destination match on rb gives `x_val = mem_alu_res`. A match on rc, when not immediate, gives `y_val = mem_alu_res`.
- R4: When `ex_imm` is 1, `y_val` always equals `ex_y_rf`, and an rc match never causes a stall.
- R5: When stage 4 and stage 5 both match the same source, the stage-4 value is selected.
- R6: A load in stage 4 never supplies a value. `ld_stall` is 1 exactly when the execute-stage instruction is ALU-class, stage 4 holds a load, and the load destination equals rb, or equals rc with `ex_imm` = 0.
- R7: Bubbles (class 0), stores (class 3) and branches (class 4) in stage 4 or stage 5 never change `x_val` or `y_val` and never raise `ld_stall`.
- R8: When the execute-stage instruction is not ALU-class, `x_val = ex_x_rf`, `y_val = ex_y_rf` and `ld_stall` = 0.
- R9: Class codes are 0 bubble, 1 ALU, 2 load, 3 store, 4 branch. Codes 5 to 7 are treated as non-writing bubbles.
- R10: A chain of back-to-back dependent ALU instructions runs with `ld_stall` held at 0, and every consumer sees its architecturally correct operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_cls | input | 3 | Opcode class of the execute-stage instruction |
| ex_rb | input | REG_W | First source register index in execute |
| ex_rc | input | REG_W | Second source register index in execute |
| ex_imm | input | 1 | Execute-stage instruction uses an immediate second operand |
| ex_x_rf | input | DATA_W | First operand as read from the register file |
| ex_y_rf | input | DATA_W | Second operand from the register file, or the immediate |
| mem_cls | input | 3 | Opcode class of the stage-4 instruction |
| mem_ra | input | REG_W | Destination register of the stage-4 instruction |
| mem_alu_res | input | DATA_W | ALU result held in the stage-4 register |
| wb_cls | input | 3 | Opcode class of the stage-5 instruction |
| wb_ra | input | REG_W | Destination register of the stage-5 instruction |
| wb_res | input | DATA_W | Computed or loaded result held in the stage-5 register |
| x_val | output | DATA_W | First operand for the ALU |
| y_val | output | DATA_W | Second operand for the ALU |
| ld_stall | output | 1 | Request to hold execute for one cycle because of a load-use dependence |

## Verification
The directed patterns cover each source alone (stage 5 on rb, stage 5 on rc, stage 4 on both). They also cover both sources hitting the same register, which shows whether the newer value wins. Some patterns place a stage-4 load against both operand slots, with and without an immediate, to separate a real load-use stall from a false one. Others put stores, branches, bubbles and unused class codes in the source stages, and non-ALU instructions in execute, to show they are inert. A small pipeline model then runs a program of dependent ALU instructions at distances one to three, followed by a load with a consumer right behind it. The model checks every operand against sequential execution and counts the stalls, which must be exactly one.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4
  } op_cls_e;

  // Only ALU and load instructions produce a register result.
  function automatic logic cls_writes(input logic [CLS_W-1:0] c);
    return (c == CLS_ALU) || (c == CLS_LOAD);
  endfunction
endpackage

// File: rtl/opfwd_src_match.sv
// Compares one producer stage against the execute-stage sources.
module opfwd_src_match
  import opfwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter bit LOAD_OK = 1'b1   // 0: loaded data is not ready in this stage
) (
  input  logic [CLS_W-1:0] src_cls,
  input  logic [REG_W-1:0] src_ra,
  input  logic             cons_alu,
  input  logic             cons_imm,
  input  logic [REG_W-1:0] cons_rb,
  input  logic [REG_W-1:0] cons_rc,
  output logic             hit_x,
  output logic             hit_y,
  output logic             wait_req
);
  logic match_b;
  logic match_c;
  logic can_fwd;
  logic is_load;

  always_comb begin
    match_b = cons_alu && (src_ra == cons_rb);
    match_c = cons_alu && !cons_imm && (src_ra == cons_rc);
    is_load = (src_cls == CLS_LOAD);
  end

  generate
    if (LOAD_OK) begin : g_any_writer
      always_comb begin
        can_fwd  = cls_writes(src_cls);
        wait_req = 1'b0;
      end
    end else begin : g_alu_only
      always_comb begin
        can_fwd  = (src_cls == CLS_ALU);
        wait_req = is_load && (match_b || match_c);
      end
    end
  endgenerate

  always_comb begin
    hit_x = can_fwd && match_b;
    hit_y = can_fwd && match_c;
  end
endmodule

// File: rtl/opfwd_opnd_sel.sv
// Picks one operand: nearest producer first, then the older one, then the register file.
module opfwd_opnd_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rf_val,
  input  logic              near_hit,
  input  logic [DATA_W-1:0] near_val,
  input  logic              far_hit,
  input  logic [DATA_W-1:0] far_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    if (near_hit)     opnd = near_val;
    else if (far_hit) opnd = far_val;
    else              opnd = rf_val;
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [2:0]        ex_cls,
  input  logic [REG_W-1:0]  ex_rb,
  input  logic [REG_W-1:0]  ex_rc,
  input  logic              ex_imm,
  input  logic [DATA_W-1:0] ex_x_rf,
  input  logic [DATA_W-1:0] ex_y_rf,
  input  logic [2:0]        mem_cls,
  input  logic [REG_W-1:0]  mem_ra,
  input  logic [DATA_W-1:0] mem_alu_res,
  input  logic [2:0]        wb_cls,
  input  logic [REG_W-1:0]  wb_ra,
  input  logic [DATA_W-1:0] wb_res,
  output logic [DATA_W-1:0] x_val,
  output logic [DATA_W-1:0] y_val,
  output logic              ld_stall
);
  localparam int NOPND = 2;

  logic cons_alu;
  logic m_hx, m_hy, m_wait;
  logic w_hx, w_hy, w_wait;

  always_comb cons_alu = (ex_cls == CLS_ALU);

  // Stage 4: only ALU results are ready here.
  opfwd_src_match #(.REG_W(REG_W), .LOAD_OK(1'b0)) u_mem_match (
    .src_cls (mem_cls),  .src_ra (mem_ra),
    .cons_alu(cons_alu), .cons_imm(ex_imm),
    .cons_rb (ex_rb),    .cons_rc (ex_rc),
    .hit_x   (m_hx),     .hit_y   (m_hy),   .wait_req(m_wait)
  );

  // Stage 5: both computed and loaded results are ready.
  opfwd_src_match #(.REG_W(REG_W), .LOAD_OK(1'b1)) u_wb_match (
    .src_cls (wb_cls),   .src_ra (wb_ra),
    .cons_alu(cons_alu), .cons_imm(ex_imm),
    .cons_rb (ex_rb),    .cons_rc (ex_rc),
    .hit_x   (w_hx),     .hit_y   (w_hy),   .wait_req(w_wait)
  );

  logic [NOPND-1:0]             near_hit;
  logic [NOPND-1:0]             far_hit;
  logic [NOPND-1:0][DATA_W-1:0] rf_vals;
  logic [NOPND-1:0][DATA_W-1:0] sel_vals;

  always_comb begin
    near_hit = {m_hy, m_hx};
    far_hit  = {w_hy, w_hx};
    rf_vals  = {ex_y_rf, ex_x_rf};
  end

  generate
    for (genvar i = 0; i < NOPND; i++) begin : g_opnd
      opfwd_opnd_sel #(.DATA_W(DATA_W)) u_sel (
        .rf_val  (rf_vals[i]),
        .near_hit(near_hit[i]), .near_val(mem_alu_res),
        .far_hit (far_hit[i]),  .far_val (wb_res),
        .opnd    (sel_vals[i])
      );
    end
  endgenerate

  always_comb begin
    x_val    = sel_vals[0];
    y_val    = sel_vals[1];
    ld_stall = m_wait | w_wait;
  end
endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [2:0]        ex_cls,
  input logic [REG_W-1:0]  ex_rb,
  input logic [REG_W-1:0]  ex_rc,
  input logic              ex_imm,
  input logic [DATA_W-1:0] ex_x_rf,
  input logic [DATA_W-1:0] ex_y_rf,
  input logic [2:0]        mem_cls,
  input logic [REG_W-1:0]  mem_ra,
  input logic [DATA_W-1:0] mem_alu_res,
  input logic [2:0]        wb_cls,
  input logic [REG_W-1:0]  wb_ra,
  input logic [DATA_W-1:0] wb_res,
  input logic [DATA_W-1:0] x_val,
  input logic [DATA_W-1:0] y_val,
  input logic              ld_stall
);
  logic mem_w, wb_w;
  always_comb begin
    mem_w = (mem_cls == 3'd1) || (mem_cls == 3'd2);
    wb_w  = (wb_cls == 3'd1) || (wb_cls == 3'd2);
  end

  always_comb begin
    // R4: an immediate second operand is never replaced
    a_r4_imm_keeps_y: assert (!(ex_imm && y_val != ex_y_rf))
      else $error("immediate operand replaced");
    // R6: a stall request only ever comes from a load in stage 4
    a_r6_stall_from_load: assert (!ld_stall || (mem_cls == 3'd2 && ex_cls == 3'd1))
      else $error("stall without stage-4 load");
    // R7: with no writer downstream the register-file values pass straight through
    a_r7_no_writer_pass: assert (mem_w || wb_w || (x_val == ex_x_rf && y_val == ex_y_rf && !ld_stall))
      else $error("non-writer acted as source");
    // R8: non-ALU consumers are untouched
    a_r8_non_alu_pass: assert (ex_cls == 3'd1 || (x_val == ex_x_rf && y_val == ex_y_rf && !ld_stall))
      else $error("non-ALU consumer altered");
    // R5: stage-4 ALU result wins over stage 5 on rb
    a_r5_newest_wins: assert (!(ex_cls == 3'd1 && mem_cls == 3'd1 && mem_ra == ex_rb) || x_val == mem_alu_res)
      else $error("stage-4 value not preferred");
    // R1: stage-5 result reaches X when stage 4 does not match rb
    a_r1_wb_to_x: assert (!(ex_cls == 3'd1 && wb_w && wb_ra == ex_rb && !(mem_cls == 3'd1 && mem_ra == ex_rb)) || x_val == wb_res)
      else $error("stage-5 value missing on X");
  end
endmodule

bind opfwd_unit opfwd_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .ex_cls(ex_cls), .ex_rb(ex_rb), .ex_rc(ex_rc), .ex_imm(ex_imm),
  .ex_x_rf(ex_x_rf), .ex_y_rf(ex_y_rf),
  .mem_cls(mem_cls), .mem_ra(mem_ra), .mem_alu_res(mem_alu_res),
  .wb_cls(wb_cls), .wb_ra(wb_ra), .wb_res(wb_res),
  .x_val(x_val), .y_val(y_val), .ld_stall(ld_stall)
);

// File: tb/tb_opfwd_unit.sv
module tb_opfwd_unit;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int NI = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]    ex_cls, mem_cls, wb_cls;
  logic [RW-1:0] ex_rb, ex_rc, mem_ra, wb_ra;
  logic          ex_imm, ld_stall;
  logic [DW-1:0] ex_x_rf, ex_y_rf, mem_alu_res, wb_res, x_val, y_val;

  opfwd_unit #(.DATA_W(DW), .REG_W(RW)) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Directed case: drive inputs, then compare against a behavioural model.
  task automatic dir(input string req,
                     input int c3, input int rb, input int rc, input bit imm,
                     input int xr, input int yr,
                     input int c4, input int r4, input int v4,
                     input int c5, input int r5, input int v5);
    int ex_x, ex_y;
    bit stl;
    bit w5;
    @(posedge clk); #1;
    ex_cls = 3'(c3); ex_rb = RW'(rb); ex_rc = RW'(rc); ex_imm = imm;
    ex_x_rf = DW'(xr); ex_y_rf = DW'(yr);
    mem_cls = 3'(c4); mem_ra = RW'(r4); mem_alu_res = DW'(v4);
    wb_cls = 3'(c5); wb_ra = RW'(r5); wb_res = DW'(v5);
    ex_x = xr; ex_y = yr; stl = 0;
    w5 = (c5 == 1) || (c5 == 2);
    if (c3 == 1) begin
      if (w5 && r5 == rb) ex_x = v5;
      if (w5 && !imm && r5 == rc) ex_y = v5;
      if (c4 == 1 && r4 == rb) ex_x = v4;
      if (c4 == 1 && !imm && r4 == rc) ex_y = v4;
      if (c4 == 2 && (r4 == rb || (!imm && r4 == rc))) stl = 1;
    end
    @(negedge clk);
    check(req, "x_val", x_val, DW'(ex_x));
    check(req, "y_val", y_val, DW'(ex_y));
    check(req, "ld_stall", DW'(ld_stall), DW'(stl));
  endtask

  // Program for the pipeline run.
  int p_cls[NI], p_ra[NI], p_rb[NI], p_rc[NI], p_iv[NI];
  bit p_imm[NI];
  int g_x[NI], g_y[NI], g_res[NI], g_adr[NI];
  int arch[32], prf[32];

  task automatic put(input int i, input int c, input int a, input int b, input int cc, input bit im, input int iv);
    p_cls[i] = c; p_ra[i] = a; p_rb[i] = b; p_rc[i] = cc; p_imm[i] = im; p_iv[i] = iv;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int s3, s4, s5, pc, stalls;
    ex_cls = '0; ex_rb = '0; ex_rc = '0; ex_imm = 0; ex_x_rf = '0; ex_y_rf = '0;
    mem_cls = '0; mem_ra = '0; mem_alu_res = '0; wb_cls = '0; wb_ra = '0; wb_res = '0;

    // Idle state: all bubbles pass register-file values through
    dir("R7", 0, 1, 2, 0, 'h11, 'h22, 0, 1, 'haa, 0, 2, 'hbb);
    dir("R7", 1, 1, 2, 0, 'h11, 'h22, 0, 1, 'haa, 0, 2, 'hbb);
    dir("R1", 1, 3, 4, 0, 'h11, 'h22, 1, 9, 'haa, 1, 3, 'hbb);
    dir("R2", 1, 3, 4, 0, 'h11, 'h22, 0, 0, 'haa, 2, 4, 'hcc);
    dir("R3", 1, 6, 6, 0, 'h11, 'h22, 1, 6, 'hd1, 0, 0, 'h0);
    dir("R4", 1, 2, 6, 1, 'h11, 'h05, 1, 6, 'hd1, 1, 6, 'he1);
    dir("R5", 1, 7, 7, 0, 'h11, 'h22, 1, 7, 'h71, 1, 7, 'h72);
    dir("R6", 1, 8, 1, 0, 'h11, 'h22, 2, 8, 'h80, 1, 8, 'h81);
    dir("R6", 1, 1, 8, 0, 'h11, 'h22, 2, 8, 'h80, 0, 0, 'h0);
    dir("R6", 1, 1, 8, 1, 'h11, 'h22, 2, 8, 'h80, 0, 0, 'h0);
    dir("R7", 1, 5, 5, 0, 'h11, 'h22, 3, 5, 'h55, 4, 5, 'h56);
    dir("R8", 3, 5, 5, 0, 'h11, 'h22, 1, 5, 'h55, 2, 5, 'h56);
    dir("R8", 2, 5, 5, 0, 'h11, 'h22, 2, 5, 'h55, 1, 5, 'h56);
    dir("R9", 1, 5, 5, 0, 'h11, 'h22, 7, 5, 'h55, 5, 5, 'h56);

    // Pipeline run: classes 1 ALU (add), 2 load, 3 store
    put(0, 1, 1, 2, 3, 0, 0);
    put(1, 1, 4, 1, 1, 0, 0);
    put(2, 1, 5, 1, 4, 0, 0);
    put(3, 1, 6, 5, 0, 1, 5);
    put(4, 1, 1, 6, 4, 0, 0);
    put(5, 1, 7, 1, 1, 0, 0);
    put(6, 2, 8, 0, 0, 1, 8);
    put(7, 1, 9, 8, 7, 0, 0);
    put(8, 1, 10, 9, 8, 0, 0);
    put(9, 3, 10, 0, 0, 1, 4);
    put(10, 1, 11, 10, 9, 0, 0);
    for (int r = 0; r < 32; r++) begin arch[r] = r * 16 + 1; prf[r] = r * 16 + 1; end
    for (int i = 0; i < NI; i++) begin
      g_x[i] = arch[p_rb[i]];
      g_y[i] = p_imm[i] ? p_iv[i] : arch[p_rc[i]];
      g_adr[i] = g_x[i] + p_iv[i];
      if (p_cls[i] == 1) g_res[i] = g_x[i] + g_y[i];
      else               g_res[i] = g_adr[i] * 3 + 7;
      if (p_cls[i] == 1 || p_cls[i] == 2) arch[p_ra[i]] = g_res[i];
    end

    s3 = -1; s4 = -1; s5 = -1; pc = 0; stalls = 0;
    s3 = pc; pc++;
    while (s3 >= 0 || s4 >= 0 || s5 >= 0) begin
      bit exp_stl;
      @(posedge clk); #1;
      ex_cls = (s3 < 0) ? 3'd0 : 3'(p_cls[s3]);
      ex_rb = (s3 < 0) ? '0 : RW'(p_rb[s3]);
      ex_rc = (s3 < 0) ? '0 : RW'(p_rc[s3]);
      ex_imm = (s3 < 0) ? 1'b0 : p_imm[s3];
      ex_x_rf = (s3 < 0) ? '0 : DW'(prf[p_rb[s3]]);
      ex_y_rf = (s3 < 0) ? '0 : (p_imm[s3] ? DW'(p_iv[s3]) : DW'(prf[p_rc[s3]]));
      mem_cls = (s4 < 0) ? 3'd0 : 3'(p_cls[s4]);
      mem_ra = (s4 < 0) ? '0 : RW'(p_ra[s4]);
      mem_alu_res = (s4 < 0) ? '0 : (p_cls[s4] == 2 ? DW'(g_adr[s4]) : DW'(g_res[s4]));
      wb_cls = (s5 < 0) ? 3'd0 : 3'(p_cls[s5]);
      wb_ra = (s5 < 0) ? '0 : RW'(p_ra[s5]);
      wb_res = (s5 < 0) ? '0 : DW'(g_res[s5]);
      exp_stl = (s3 >= 0 && s4 >= 0 && p_cls[s3] == 1 && p_cls[s4] == 2 &&
                 (p_ra[s4] == p_rb[s3] || (!p_imm[s3] && p_ra[s4] == p_rc[s3])));
      @(negedge clk);
      check("R10", "ld_stall in chain", DW'(ld_stall), DW'(exp_stl));
      if (s3 >= 0 && p_cls[s3] == 1 && !exp_stl) begin
        check("R10", "x operand", x_val, DW'(g_x[s3]));
        check("R10", "y operand", y_val, DW'(g_y[s3]));
      end
      // advance: write-back retires, stall holds execute and injects a bubble
      if (s5 >= 0 && (p_cls[s5] == 1 || p_cls[s5] == 2)) prf[p_ra[s5]] = g_res[s5];
      s5 = s4;
      if (exp_stl) begin
        stalls++;
        s4 = -1;
      end else begin
        s4 = s3;
        s3 = (pc < NI) ? pc : -1;
        if (pc < NI) pc++;
      end
    end
    check("R6", "stall count for load-use", DW'(stalls), DW'(1));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule